// File: doc/BRIEF.md
# Predicated Move and Load Writeback Stage

This block is the final stage of a small in-order pipeline. It owns the architectural register file and retires four operation kinds. The first is an add-immediate that always writes. The second is a conditional register move, which writes only when its condition register holds zero. The third is a conditional load, which writes the fetched word only when its condition register holds a nonzero value. The fourth is a no-operation. Each operation names a destination, a source (or base) register and a condition register. The stage reads the source and condition values from its own register file, evaluates the predicate and decides whether the destination write commits.

A conditional load always sends its read to memory, whatever the predicate says. The memory answers one cycle after the request with a data word and a fault flag. When the predicate is false, the stage drops both the register write and the fault. The commit decision appears on the port as a one-cycle write strobe with the destination index and data, and the same write updates the register file at that edge.

Sequencing uses three states. ST_READY accepts an operation. A load moves the machine to ST_LD_REQ, the cycle in which the memory request is on the port. The machine then goes to ST_LD_RESP, in which the response is taken and the commit is decided, and it returns to ST_READY. Non-load operations stay in ST_READY and commit one edge after issue.

Top module: `pwb_stage`

## Requirements
- R1: After reset, wb_en, exc_valid and mem_req are low, issue_ready is high, and every register reads as zero.
- R2: Op code 2'b00 (add-immediate) writes rs + imm to rd. wb_en, wb_idx and wb_data show the write in the cycle after the issue edge.
- R3: Op code 2'b01 (conditional move) with a condition register equal to zero writes the value of rs to rd, with the same timing as R2.
- R4: A conditional move whose condition register is nonzero raises no wb_en and leaves rd unchanged.
- R5: Op code 2'b10 (conditional load) raises mem_req for exactly one cycle, in the cycle after issue, with mem_addr = rs + imm. This happens whether the predicate is true or false.
- R6: A conditional load whose condition register is nonzero writes mem_rdata (returned one cycle after mem_req) to rd. wb_en rises three cycles after the issue edge.
- R7: A conditional load whose condition register is zero raises no wb_en and leaves rd unchanged.
- R8: exc_valid pulses in a load's commit cycle if and only if mem_fault was returned and that load's predicate was true. A fault under a false predicate raises nothing.
- R9: Register 0 always reads as zero. A commit aimed at index 0 produces no wb_en.
- R10: issue_ready is low for the two cycles a load waits. An operation offered during that time is ignored.
- R11: Op code 2'b11 (no-operation) produces no write and no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An operation is offered |
| issue_ready | output | 1 | Stage can accept an operation this cycle |
| issue_op | input | 2 | Operation code (see R2, R3, R5, R11) |
| issue_rd | input | 5 | Destination register index |
| issue_rs | input | 5 | Source register (move) or base register (load, add) |
| issue_rc | input | 5 | Condition register index |
| issue_imm | input | 32 | Immediate added to the source/base value |
| mem_req | output | 1 | Memory read request pulse |
| mem_addr | output | 32 | Memory read address |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_req |
| mem_fault | input | 1 | Access fault, valid with mem_rdata |
| wb_en | output | 1 | One-cycle register commit strobe |
| wb_idx | output | 5 | Index of the committed register |
| wb_data | output | 32 | Value committed |
| exc_valid | output | 1 | Exception pulse for a faulting, predicate-true load |

## Verification
The bench sweeps every condition register against several source registers, for both predicated kinds. This covers zero and nonzero predicates, destinations that include register 0, and load addresses that land on faulting memory. A design that inverted either predicate, or that evaluated both tests the same way, would commit on the wrong half of that sweep. A design that gated the memory request on the predicate would miss the request checks on false-predicate loads. One that forgot to mask the fault would raise exc_valid on a faulting false-predicate load, and directed cases target exactly that pair. Stray operations offered while a load waits, and writes aimed at register 0, are caught later by reading every register back through add-immediate operations and comparing against a shadow model.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    typedef enum logic [1:0] {
        OP_ADDI  = 2'b00,
        OP_CMOVZ = 2'b01,
        OP_LDC   = 2'b10,
        OP_NOP   = 2'b11
    } pwb_op_e;

    typedef enum logic [1:0] {
        ST_READY   = 2'b00,
        ST_LD_REQ  = 2'b01,
        ST_LD_RESP = 2'b10
    } pwb_state_e;

endpackage

// File: rtl/pwb_regfile.sv
module pwb_regfile #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 32,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDXW-1:0]  widx,
    input  logic [WIDTH-1:0] wdata,
    input  logic [IDXW-1:0]  ridx_a,
    output logic [WIDTH-1:0] rdata_a,
    input  logic [IDXW-1:0]  ridx_b,
    output logic [WIDTH-1:0] rdata_b
);

    logic [WIDTH-1:0] cells [DEPTH];

    // entry 0 is never written and stays at its reset value of zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we && (widx != '0)) begin
            cells[widx] <= wdata;
        end
    end

    assign rdata_a = (ridx_a == '0) ? '0 : cells[ridx_a];
    assign rdata_b = (ridx_b == '0) ? '0 : cells[ridx_b];

endmodule

// File: rtl/pwb_pred.sv
module pwb_pred
    import pwb_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [1:0]       op,
    input  logic [WIDTH-1:0] cond_val,
    output logic             pred_true,
    output logic             is_load
);

    pwb_op_e op_e;
    logic    cond_zero;

    assign op_e      = pwb_op_e'(op);
    assign cond_zero = (cond_val == '0);

    always_comb begin
        pred_true = 1'b0;
        is_load   = 1'b0;
        unique case (op_e)
            OP_ADDI:  pred_true = 1'b1;
            OP_CMOVZ: pred_true = cond_zero;
            OP_LDC: begin
                pred_true = !cond_zero;
                is_load   = 1'b1;
            end
            OP_NOP:   pred_true = 1'b0;
            default:  pred_true = 1'b0;
        endcase
    end

endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
    import pwb_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int IDXW  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_valid,
    input  logic [1:0]       op,
    input  logic [IDXW-1:0]  rd,
    input  logic [WIDTH-1:0] rs_val,
    input  logic [WIDTH-1:0] imm,
    input  logic             pred_true,
    input  logic             is_load,
    input  logic [WIDTH-1:0] mem_rdata,
    input  logic             mem_fault,
    output logic             issue_ready,
    output logic             commit_we,
    output logic [IDXW-1:0]  commit_idx,
    output logic [WIDTH-1:0] commit_data,
    output logic             mem_req,
    output logic [WIDTH-1:0] mem_addr,
    output logic             wb_en,
    output logic [IDXW-1:0]  wb_idx,
    output logic [WIDTH-1:0] wb_data,
    output logic             exc_valid
);

    pwb_state_e       state, nxt_state;
    logic [IDXW-1:0]  ld_rd_q;
    logic             ld_pred_q;
    logic             c_exc, c_req, c_cap;
    logic [WIDTH-1:0] c_addr;

    assign issue_ready = (state == ST_READY);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_READY;
        else        state <= nxt_state;
    end

    // next state and commit decision
    always_comb begin
        nxt_state   = state;
        commit_we   = 1'b0;
        commit_idx  = rd;
        commit_data = '0;
        c_exc       = 1'b0;
        c_req       = 1'b0;
        c_addr      = mem_addr;
        c_cap       = 1'b0;
        unique case (state)
            ST_READY: begin
                if (issue_valid) begin
                    if (is_load) begin
                        nxt_state = ST_LD_REQ;
                        c_req     = 1'b1;
                        c_addr    = rs_val + imm;
                        c_cap     = 1'b1;
                    end else begin
                        commit_we   = pred_true && (rd != '0);
                        commit_idx  = rd;
                        commit_data = (pwb_op_e'(op) == OP_CMOVZ) ? rs_val : rs_val + imm;
                    end
                end
            end
            ST_LD_REQ: begin
                nxt_state = ST_LD_RESP;
            end
            ST_LD_RESP: begin
                nxt_state   = ST_READY;
                commit_we   = ld_pred_q && (ld_rd_q != '0);
                commit_idx  = ld_rd_q;
                commit_data = mem_rdata;
                c_exc       = mem_fault && ld_pred_q;
            end
            default: nxt_state = ST_READY;
        endcase
    end

    // registered outputs and pending-load context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_en     <= 1'b0;
            wb_idx    <= '0;
            wb_data   <= '0;
            exc_valid <= 1'b0;
            mem_req   <= 1'b0;
            mem_addr  <= '0;
            ld_rd_q   <= '0;
            ld_pred_q <= 1'b0;
        end else begin
            wb_en     <= commit_we;
            wb_idx    <= commit_idx;
            wb_data   <= commit_data;
            exc_valid <= c_exc;
            mem_req   <= c_req;
            mem_addr  <= c_addr;
            if (c_cap) begin
                ld_rd_q   <= rd;
                ld_pred_q <= pred_true;
            end
        end
    end

endmodule

// File: rtl/pwb_stage.sv
module pwb_stage #(
    parameter int NREGS = 32,
    parameter int WIDTH = 32,
    localparam int IDXW = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_valid,
    output logic             issue_ready,
    input  logic [1:0]       issue_op,
    input  logic [IDXW-1:0]  issue_rd,
    input  logic [IDXW-1:0]  issue_rs,
    input  logic [IDXW-1:0]  issue_rc,
    input  logic [WIDTH-1:0] issue_imm,
    output logic             mem_req,
    output logic [WIDTH-1:0] mem_addr,
    input  logic [WIDTH-1:0] mem_rdata,
    input  logic             mem_fault,
    output logic             wb_en,
    output logic [IDXW-1:0]  wb_idx,
    output logic [WIDTH-1:0] wb_data,
    output logic             exc_valid
);

    logic [WIDTH-1:0] rs_val, rc_val, commit_data;
    logic [IDXW-1:0]  commit_idx;
    logic             commit_we, pred_true, is_load;

    pwb_regfile #(.DEPTH(NREGS), .WIDTH(WIDTH)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (commit_we),
        .widx    (commit_idx),
        .wdata   (commit_data),
        .ridx_a  (issue_rs),
        .rdata_a (rs_val),
        .ridx_b  (issue_rc),
        .rdata_b (rc_val)
    );

    pwb_pred #(.WIDTH(WIDTH)) u_pred (
        .op        (issue_op),
        .cond_val  (rc_val),
        .pred_true (pred_true),
        .is_load   (is_load)
    );

    pwb_ctrl #(.WIDTH(WIDTH), .IDXW(IDXW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_valid (issue_valid),
        .op          (issue_op),
        .rd          (issue_rd),
        .rs_val      (rs_val),
        .imm         (issue_imm),
        .pred_true   (pred_true),
        .is_load     (is_load),
        .mem_rdata   (mem_rdata),
        .mem_fault   (mem_fault),
        .issue_ready (issue_ready),
        .commit_we   (commit_we),
        .commit_idx  (commit_idx),
        .commit_data (commit_data),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .wb_en       (wb_en),
        .wb_idx      (wb_idx),
        .wb_data     (wb_data),
        .exc_valid   (exc_valid)
    );

endmodule

module pwb_stage_chk #(
    parameter int WIDTH = 32,
    parameter int IDXW  = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             issue_ready,
    input logic             mem_req,
    input logic [WIDTH-1:0] mem_rdata,
    input logic             wb_en,
    input logic [IDXW-1:0]  wb_idx,
    input logic [WIDTH-1:0] wb_data,
    input logic             exc_valid
);

    // R5
    mem_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R10
    busy_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !issue_ready);

    // R10
    busy_on_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mem_req) |-> !issue_ready);

    // R9
    no_r0_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (wb_idx != '0));

    // R8
    exc_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> $past(mem_req, 2));

    // R6
    load_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && $past(mem_req, 2)) |-> (wb_data == $past(mem_rdata)));

endmodule

bind pwb_stage pwb_stage_chk #(.WIDTH(WIDTH), .IDXW(IDXW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_ready (issue_ready),
    .mem_req     (mem_req),
    .mem_rdata   (mem_rdata),
    .wb_en       (wb_en),
    .wb_idx      (wb_idx),
    .wb_data     (wb_data),
    .exc_valid   (exc_valid)
);

// File: tb/sim_pwb_stage.sv
`timescale 1ns/1ps
module sim_pwb_stage;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        issue_valid, issue_ready;
    logic [1:0]  issue_op;
    logic [4:0]  issue_rd, issue_rs, issue_rc;
    logic [31:0] issue_imm;
    logic        mem_req;
    logic [31:0] mem_addr, mem_rdata;
    logic        mem_fault;
    logic        wb_en;
    logic [4:0]  wb_idx;
    logic [31:0] wb_data;
    logic        exc_valid;

    int checks = 0;
    int errors = 0;
    logic [31:0] sh [32];

    always #2 clk = ~clk;

    pwb_stage u0 (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
        .issue_op(issue_op), .issue_rd(issue_rd), .issue_rs(issue_rs), .issue_rc(issue_rc),
        .issue_imm(issue_imm), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_fault(mem_fault), .wb_en(wb_en), .wb_idx(wb_idx),
        .wb_data(wb_data), .exc_valid(exc_valid)
    );

    function automatic logic [31:0] mem_fn(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    function automatic logic mem_flt(input logic [31:0] a);
        return a[7:4] == 4'hC;
    endfunction

    // memory with one cycle of read latency
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rdata <= '0;
            mem_fault <= 1'b0;
        end else if (mem_req) begin
            mem_rdata <= mem_fn(mem_addr);
            mem_fault <= mem_flt(mem_addr);
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // issue one operation at a negedge and check its outcome; returns at a negedge
    task automatic run_op(input logic [1:0] op, input logic [4:0] rd, input logic [4:0] rs,
                          input logic [4:0] rc, input logic [31:0] imm, input string req);
        logic [31:0] ex_data, ex_addr;
        logic        ex_pred, ex_we, ex_exc;
        ex_addr = sh[rs] + imm;
        case (op)
            2'b00:   begin ex_pred = 1'b1;          ex_data = sh[rs] + imm;    end
            2'b01:   begin ex_pred = (sh[rc] == 0); ex_data = sh[rs];          end
            2'b10:   begin ex_pred = (sh[rc] != 0); ex_data = mem_fn(ex_addr); end
            default: begin ex_pred = 1'b0;          ex_data = '0;              end
        endcase
        ex_we  = ex_pred && (rd != 0);
        ex_exc = (op == 2'b10) && ex_pred && mem_flt(ex_addr);
        chk(issue_ready == 1'b1, "R10", "ready before issue", {31'b0, issue_ready}, 32'd1);
        issue_valid = 1'b1; issue_op = op; issue_rd = rd; issue_rs = rs;
        issue_rc = rc; issue_imm = imm;
        @(negedge clk);
        if (op == 2'b10) begin
            // R5: request issued regardless of predicate
            chk(mem_req == 1'b1, "R5", "mem_req", {31'b0, mem_req}, 32'd1);
            chk(mem_addr == ex_addr, "R5", "mem_addr", mem_addr, ex_addr);
            chk(issue_ready == 1'b0, "R10", "ready during wait", {31'b0, issue_ready}, 32'd0);
            // R10: stray operation while busy must be ignored
            issue_op = 2'b00; issue_rd = 5'd5; issue_rs = 5'd0; issue_imm = 32'hDEAD_0001;
            @(negedge clk);
            chk(mem_req == 1'b0, "R5", "mem_req single cycle", {31'b0, mem_req}, 32'd0);
            chk(wb_en == 1'b0, "R10", "no commit while busy", {31'b0, wb_en}, 32'd0);
            @(negedge clk);
        end else begin
            // R11 and the non-load ops never touch memory
            chk(mem_req == 1'b0, "R11", "no mem_req", {31'b0, mem_req}, 32'd0);
        end
        issue_valid = 1'b0;
        chk(wb_en == ex_we, req, "wb_en", {31'b0, wb_en}, {31'b0, ex_we});
        if (ex_we) begin
            chk(wb_idx == rd, req, "wb_idx", {27'b0, wb_idx}, {27'b0, rd});
            chk(wb_data == ex_data, req, "wb_data", wb_data, ex_data);
            sh[rd] = ex_data;
        end
        chk(exc_valid == ex_exc, "R8", "exc_valid", {31'b0, exc_valid}, {31'b0, ex_exc});
    endtask

    // read a register back through an add-immediate into scratch r31
    task automatic read_reg(input logic [4:0] x, input string req);
        logic [31:0] v;
        v = sh[x];
        run_op(2'b00, 5'd31, x, 5'd0, 32'd0, req);
        chk(wb_data == v, req, "readback", wb_data, v);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        summary();
    end

    initial begin
        for (int i = 0; i < 32; i++) sh[i] = '0;
        rst_n = 1'b0; issue_valid = 1'b0; issue_op = '0; issue_rd = '0;
        issue_rs = '0; issue_rc = '0; issue_imm = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(wb_en == 1'b0, "R1", "wb_en", {31'b0, wb_en}, 32'd0);
        chk(exc_valid == 1'b0, "R1", "exc_valid", {31'b0, exc_valid}, 32'd0);
        chk(mem_req == 1'b0, "R1", "mem_req", {31'b0, mem_req}, 32'd0);
        chk(issue_ready == 1'b1, "R1", "issue_ready", {31'b0, issue_ready}, 32'd1);
        read_reg(5'd7, "R1");

        // R2: load every register, every fourth one with zero
        for (int r = 1; r < 32; r++)
            run_op(2'b00, 5'(r), 5'd0, 5'd0, (r % 4 == 0) ? 32'd0 : r * 32'h0011_2233 + 5, "R2");
        run_op(2'b00, 5'd9, 5'd3, 5'd0, 32'hFFFF_FFF0, "R2");

        // R9
        run_op(2'b00, 5'd0, 5'd3, 5'd0, 32'd55, "R9");
        read_reg(5'd0, "R9");

        // R11
        run_op(2'b11, 5'd6, 5'd3, 5'd0, 32'd1, "R11");
        read_reg(5'd6, "R11");

        // directed fault cases, both predicates (R8)
        run_op(2'b10, 5'd10, 5'd2, 5'd4, 32'h0000_00C0 - sh[2], "R7");
        run_op(2'b10, 5'd11, 5'd2, 5'd3, 32'h0000_00C4 - sh[2], "R6");
        read_reg(5'd10, "R7");

        // sweep all condition registers against several sources
        for (int rc = 0; rc < 32; rc++) begin
            for (int k = 0; k < 4; k++) begin
                logic [4:0] rs, rd;
                rs = 5'((rc * 5 + k * 7 + 1) % 31);
                rd = 5'((rc * 7 + k * 3) % 31);
                run_op(2'b01, rd, rs, 5'(rc), 32'd0, (sh[rc] == 0) ? "R3" : "R4");
                rd = 5'((rc * 3 + k * 11 + 2) % 31);
                run_op(2'b10, rd, rs, 5'(rc), 32'(rc * 16 + k * 4), (sh[rc] != 0) ? "R6" : "R7");
            end
        end

        // R4 R7 R10: every register matches the shadow after the sweep
        for (int x = 0; x < 31; x++) read_reg(5'(x), "R10");

        summary();
    end

endmodule